// File: doc/BRIEF.md
# Floating-Point Compare Unit

This block compares two 64-bit double-precision floating-point words. A 2-bit opcode selects one of four tests: unordered, equal, less-than and less-or-equal. The answer comes back as a 64-bit result word. A separate flag reports an invalid operation.

The comparison works directly on the packed sign, exponent and fraction fields. Values are ordered as sign-magnitude numbers, so no operand is unpacked or normalised first.

An operand is presented together with a valid strobe. The result, the flag and an output valid appear on the next clock. A cycle with no valid input clears all outputs to zero on the following clock.

Top module: `fpcmp_unit`

## Requirements
- R1: A true result is the word 0x4000000000000000, with only bit 62 set. A false result is all zeros. No other result value ever appears.
- R2: An operand is a NaN when its exponent field (bits 62..52) is all ones and its fraction (bits 51..0) is nonzero. It is quiet when fraction bit 51 is set and signalling otherwise. The unordered test returns true when either operand is a NaN.
- R3: The unordered test returns false when neither operand is a NaN. Infinities count as ordered.
- R4: The equal, less-than and less-or-equal tests return false whenever either operand is a NaN.
- R5: For every opcode, invalidFlag is 1 when either operand is a signalling NaN and 0 otherwise. Quiet NaNs do not raise it.
- R6: Two zeros of any signs are equal. Equal and less-or-equal return true for them, and less-than returns false.
- R7: Apart from zeros, two ordered operands are equal exactly when their full 64-bit words are identical.
- R8: When the signs differ and the operands are not both zero, the negative operand (bit 63 set) is the smaller.
- R9: When the signs are the same, order follows exponent and then fraction. A larger magnitude is larger among positive values and smaller among negative values. Less-or-equal is true exactly when less-than or equal is true.
- R10: Opcode encoding on opSel: 00 unordered, 01 equal, 10 less-than, 11 less-or-equal.
- R11: Results are registered. The outputs for an input accepted with inValid=1 at a clock edge appear at that edge, with outValid=1. After an edge at which inValid=0, outValid, resultWord and invalidFlag are all 0.
- R12: While rstN is low, outValid, resultWord and invalidFlag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and opcode are valid this cycle |
| opSel | input | 2 | Compare opcode |
| opA | input | 64 | First operand, double-precision word |
| opB | input | 64 | Second operand, double-precision word |
| outValid | output | 1 | Result registered from a valid input |
| resultWord | output | 64 | True or false word |
| invalidFlag | output | 1 | Signalling NaN seen on an operand |

## Verification
Every output of this block is due exactly one clock edge after its inputs are accepted. The bench applies inputs on the falling edge. It computes the expected outValid, result word and flag from those inputs with an independent reference model, then samples and compares on the next falling edge. Checks therefore always fall half a cycle after the edge that registers the answer.

The reference model orders values by mapping each word to a signed integer key. Stimulus includes directed cases for NaN kinds, signed zeros, infinities and each sign and magnitude ordering, plus idle cycles and random operands drawn from a pool of special values.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int MAG_W  = EXP_W + FRAC_W;
  localparam int QUIET_BIT = FRAC_W - 1;
  localparam int TRUE_BIT  = WORD_W - 2;
  localparam logic [WORD_W-1:0] TRUE_WORD  = {{(WORD_W-1-TRUE_BIT){1'b0}}, 1'b1, {TRUE_BIT{1'b0}}};
  localparam logic [WORD_W-1:0] FALSE_WORD = '0;

  typedef enum logic [1:0] {
    CMP_UNORD = 2'b00,
    CMP_EQ    = 2'b01,
    CMP_LT    = 2'b10,
    CMP_LE    = 2'b11
  } cmpOp_e;

  typedef struct packed {
    logic load;
    logic clear;
  } cmpStrobe_t;
endpackage

// File: rtl/fpcmp_ctrl.sv
module fpcmp_ctrl
  import fpcmp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output cmpStrobe_t strobe,
  output logic       outValid
);
  always_comb begin
    strobe.load  = inValid;
    strobe.clear = ~inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R11
  AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R11
endmodule

// File: rtl/fpcmp_dp.sv
module fpcmp_dp
  import fpcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cmpStrobe_t        strobe,
  input  logic [1:0]        opSel,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [WORD_W-1:0] resultWord,
  output logic              invalidFlag
);
  logic [WORD_W-1:0] operand [2];
  logic [1:0] isNan, isSnan, isZero, signBit;
  logic [MAG_W-1:0] mag [2];

  assign operand[0] = opA;
  assign operand[1] = opB;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : gClassify
      logic [EXP_W-1:0]  expField;
      logic [FRAC_W-1:0] fracField;
      assign expField   = operand[g][WORD_W-2 -: EXP_W];
      assign fracField  = operand[g][FRAC_W-1:0];
      assign signBit[g] = operand[g][WORD_W-1];
      assign mag[g]     = operand[g][MAG_W-1:0];
      assign isNan[g]   = (&expField) && (|fracField);
      assign isSnan[g]  = isNan[g] && !fracField[QUIET_BIT];
      assign isZero[g]  = (mag[g] == '0);
    end
  endgenerate

  logic anyNan, anySnan, bothZero, ordEq, ordLt, cmpTrue;

  always_comb begin
    anyNan   = |isNan;
    anySnan  = |isSnan;
    bothZero = &isZero;
    ordEq    = bothZero || (opA == opB);
    if (bothZero)                  ordLt = 1'b0;
    else if (signBit[0] != signBit[1]) ordLt = signBit[0];
    else if (signBit[0])           ordLt = mag[0] > mag[1];
    else                           ordLt = mag[0] < mag[1];
    case (cmpOp_e'(opSel))
      CMP_UNORD: cmpTrue = anyNan;
      CMP_EQ:    cmpTrue = !anyNan && ordEq;
      CMP_LT:    cmpTrue = !anyNan && ordLt;
      default:   cmpTrue = !anyNan && (ordLt || ordEq);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      resultWord  <= FALSE_WORD;
      invalidFlag <= 1'b0;
    end else if (strobe.load) begin
      resultWord  <= cmpTrue ? TRUE_WORD : FALSE_WORD;
      invalidFlag <= anySnan;
    end
  end

  AST_RESULT_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (resultWord == FALSE_WORD) || (resultWord == TRUE_WORD)); // R1
  AST_NAN_FALSE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && anyNan && opSel != CMP_UNORD) |=> (resultWord == FALSE_WORD)); // R4
  AST_NAN_UNORD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && anyNan && opSel == CMP_UNORD) |=> (resultWord == TRUE_WORD)); // R2
  AST_SNAN_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && anySnan) |=> invalidFlag); // R5
  AST_ZERO_EQUAL: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && bothZero && opSel == CMP_EQ) |=> (resultWord == TRUE_WORD)); // R6
  AST_ZERO_NOT_LESS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && bothZero && opSel == CMP_LT) |=> (resultWord == FALSE_WORD)); // R6
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
  import fpcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        opSel,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic              outValid,
  output logic [WORD_W-1:0] resultWord,
  output logic              invalidFlag
);
  cmpStrobe_t strobe;

  fpcmp_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  fpcmp_dp uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .opSel       (opSel),
    .opA         (opA),
    .opB         (opB),
    .resultWord  (resultWord),
    .invalidFlag (invalidFlag)
  );

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (resultWord == '0 && !invalidFlag)); // R11
endmodule

// File: tb/fpcmp_unit_test.sv
module fpcmp_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] opSel = 2'b00;
  logic [63:0] opA = '0, opB = '0;
  logic outValid, invalidFlag;
  logic [63:0] resultWord;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic expValid, expFlag;
  logic [63:0] expWord;

  localparam logic [63:0] T_WORD = 64'h4000_0000_0000_0000;
  localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] PZERO = 64'h0;
  localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONE = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] TWO = 64'h4000_0000_0000_0000;
  localparam logic [63:0] NONE = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] NTWO = 64'hC000_0000_0000_0000;

  always #5 clk = ~clk;

  fpcmp_unit uut (.clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .opA(opA), .opB(opB), .outValid(outValid), .resultWord(resultWord),
    .invalidFlag(invalidFlag));

  function automatic bit nanOf(logic [63:0] w);
    return (w[62:52] == 11'h7FF) && (w[51:0] != 0);
  endfunction
  function automatic bit sigOf(logic [63:0] w);
    return nanOf(w) && !w[51];
  endfunction
  function automatic longint keyOf(logic [63:0] w);
    longint m;
    m = longint'({1'b0, w[62:0]});
    return w[63] ? -m : m;
  endfunction

  function automatic bit refTrue(logic [1:0] op, logic [63:0] a, logic [63:0] b);
    bit nan;
    longint ka, kb;
    nan = nanOf(a) || nanOf(b);
    ka = keyOf(a);
    kb = keyOf(b);
    if (op == 2'd0) return nan;
    if (nan) return 0;
    if (op == 2'd1) return ka == kb;
    if (op == 2'd2) return ka < kb;
    return ka <= kb;
  endfunction

  task automatic compareOut(string req);
    checks++;
    if (outValid !== expValid || resultWord !== expWord || invalidFlag !== expFlag) begin
      failures++;
      $display("FAIL %s: got valid=%b word=%h flag=%b, expected valid=%b word=%h flag=%b",
        req, outValid, resultWord, invalidFlag, expValid, expWord, expFlag);
    end
  endtask

  task automatic doCmp(string req, logic [1:0] op, logic [63:0] a, logic [63:0] b);
    inValid = 1'b1; opSel = op; opA = a; opB = b;
    expValid = 1'b1;
    expWord = refTrue(op, a, b) ? T_WORD : 64'h0;
    expFlag = sigOf(a) || sigOf(b);
    @(negedge clk);
    compareOut(req);
  endtask

  task automatic doIdle(string req);
    inValid = 1'b0; opSel = 2'b11; opA = SNAN; opB = QNAN;
    expValid = 1'b0; expWord = '0; expFlag = 1'b0;
    @(negedge clk);
    compareOut(req);
  endtask

  initial begin
    logic [63:0] pool [12];
    pool = '{QNAN, SNAN, PINF, NINF, PZERO, NZERO, ONE, TWO, NONE, NTWO,
             64'h3FF0_0000_0000_0001, 64'hBFF0_0000_0000_0001};
    expValid = 0; expWord = '0; expFlag = 0;
    repeat (3) @(negedge clk);
    compareOut("R12");
    rstN = 1'b1;
    // R2 / R5: unordered with quiet and signalling NaN
    doCmp("R2", 2'b00, QNAN, ONE);
    doCmp("R5", 2'b00, ONE, SNAN);
    doCmp("R3", 2'b00, PINF, NINF);
    doCmp("R4", 2'b01, QNAN, QNAN);
    doCmp("R4", 2'b11, SNAN, ONE);
    doCmp("R6", 2'b01, PZERO, NZERO);
    doCmp("R6", 2'b10, NZERO, PZERO);
    doCmp("R6", 2'b11, PZERO, NZERO);
    doCmp("R7", 2'b01, ONE, ONE);
    doCmp("R7", 2'b01, ONE, 64'h3FF0_0000_0000_0001);
    doCmp("R8", 2'b10, NONE, ONE);
    doCmp("R8", 2'b10, PZERO, NINF);
    doCmp("R9", 2'b10, NTWO, NONE);
    doCmp("R9", 2'b10, ONE, TWO);
    doCmp("R9", 2'b11, 64'hBFF0_0000_0000_0001, NONE);
    doCmp("R10", 2'b11, TWO, TWO);
    doCmp("R1", 2'b10, TWO, ONE);
    doIdle("R11");
    doCmp("R11", 2'b00, SNAN, SNAN);
    doIdle("R11");
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      a = (i % 3 == 0) ? {$urandom, $urandom} : pool[$urandom_range(0, 11)];
      b = (i % 5 == 0) ? {$urandom, $urandom} : pool[$urandom_range(0, 11)];
      if (i % 17 == 0) doIdle("R11");
      else doCmp("R9", 2'($urandom_range(0, 3)), a, b);
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule